// File: doc/BRIEF.md
# ADC Conversion Controller with Offset Correction

This block is the digital side of a 13-bit analog-to-digital converter. Software reaches it through four 16-bit registers on a simple write/read port. It holds one configuration word for each of 25 indices, and a write that sets the start bit launches one conversion using the word at the current index. The controller drives the channel, input-mode and gain selections to the converter. It takes back one behavioural sample, adds a signed correction to it, saturates the sum, and stores the result in a 25-entry result buffer.

Channel code 25 does not select a pin. It ties the converter input to internal ground so that the converter's own offset can be measured. No buffer slot belongs to that code, so software sets location override. The result then lands in the alternate slot named inside the configuration word.

Software cancels a measured offset by loading the two's-complement negative of it into the correction register. A power-on reset puts that register back to its fixed factory value.

Top module: `adc_offset_conv_ctrl`

## Requirements
- R1: After reset the block is idle. Busy and done are low, the control and index registers read 0, every configuration word and every buffer slot reads 0, and the correction register reads the factory value (default -3, read as 16'hFFFD).
- R2: Register addresses are 0 for control, 1 for index, 2 for data and 3 for correction. The index register holds the entry number in bits [4:0] and the config-select flag in bit 5. When config-select is 1, a write to data stores the 16-bit word in configuration entry [index], and a read of data returns that entry. Indices 25 to 31 store nothing and read as 0.
- R3: When config-select is 0, a write to data changes nothing, and a read of data returns buffer slot [index], zero-extended.
- R4: A control write with bit 0 set, made while idle, starts a conversion of configuration entry [index]. In the next cycle adc_start pulses for exactly one cycle. During the conversion, adc_chan carries word bits [4:0], adc_diff carries bit 5 and adc_gain carries bits [14:13] (0 = gain 1, 2 = gain 3, 3 = gain 4). These values are held until the conversion ends.
- R5: adc_gnd_sel is high exactly when the selected channel code is 25, the internal-ground offset measurement.
- R6: With override off (control bit 1 = 0), the result goes to the slot equal to the channel code. Channel codes 25 to 31 write no slot.
- R7: With override on, the result goes to the slot given by word bits [12:8]. An alternate slot of 25 or more writes nothing.
- R8: The stored result is the sample plus the signed 13-bit correction, clamped to the range 0 to 8191. The correction register reads back sign-extended to 16 bits.
- R9: Busy rises with adc_start. It stays high until the buffer write, two cycles after the cycle in which adc_sample_valid is accepted. Done then pulses for one cycle with busy low.
- R10: A start request made while busy has no effect. No further adc_start follows, and only one done is produced.
- R11: A reset after a calibration discards the correction value written by software and restores the factory value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | 16 | Register read data (combinational) |
| conv_busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle pulse after the result write |
| adc_start | output | 1 | One-cycle sample request to the converter |
| adc_chan | output | 5 | Selected channel code |
| adc_diff | output | 1 | Differential input mode |
| adc_gain | output | 2 | Gain code |
| adc_gnd_sel | output | 1 | Converter input tied to internal ground |
| adc_sample | input | 13 | Raw converter sample |
| adc_sample_valid | input | 1 | Sample qualifier, accepted after adc_start |

## Verification
A fault in the stored slot or the saturating adder shows in the buffer contents. The bench therefore reads back the whole buffer image after every conversion, so a write to the wrong slot or a wrapped sum is seen within a few dozen cycles. A sequencer stuck in a busy state shows as a missing done pulse three cycles after the sample is offered. A start accepted while busy shows as a second adc_start pulse in the next cycle. A lost or wrong reset value shows on the first register read after reset.

// File: rtl/adc_ctl_pkg.sv
`timescale 1ns/1ps
package adc_ctl_pkg;
  localparam int FIELD_W = 5;
  localparam int REG_W   = 16;

  typedef struct packed {
    logic               rsv_hi;
    logic [1:0]         gain;
    logic [FIELD_W-1:0] alt_loc;
    logic [1:0]         rsv_mid;
    logic               diff;
    logic [FIELD_W-1:0] chan;
  } cfg_word_t;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_OFFS = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_STORE = 2'd3
  } conv_state_e;
endpackage

// File: rtl/acq_regs.sv
`timescale 1ns/1ps
module acq_regs
  import adc_ctl_pkg::*;
#(
  parameter int RAW_W        = 13,
  parameter int NUM_LOC      = 25,
  parameter int OFFSET_RESET = -3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  output logic                    start_req,
  output logic                    start_ovr,
  output logic                    loc_ovr,
  output logic                    cfg_sel,
  output logic [FIELD_W-1:0]      idx,
  output logic signed [RAW_W-1:0] offset,
  output cfg_word_t               cfg_word
);
  localparam logic [FIELD_W-1:0] LAST_IDX = FIELD_W'(NUM_LOC - 1);

  logic                    wr_ctrl, wr_stat, wr_data_sel, wr_offs;
  logic                    loc_ovr_q, loc_ovr_d;
  logic                    cfg_sel_q, cfg_sel_d;
  logic [FIELD_W-1:0]      idx_q, idx_d;
  logic signed [RAW_W-1:0] off_q, off_d;
  logic [NUM_LOC-1:0]      cfg_we;
  cfg_word_t               cfg_q [NUM_LOC];

  assign wr_ctrl     = wr_en && (wr_addr == REG_CTRL);
  assign wr_stat     = wr_en && (wr_addr == REG_STAT);
  assign wr_data_sel = wr_en && (wr_addr == REG_DATA);
  assign wr_offs     = wr_en && (wr_addr == REG_OFFS);

  always_comb begin
    loc_ovr_d = loc_ovr_q;
    cfg_sel_d = cfg_sel_q;
    idx_d     = idx_q;
    off_d     = off_q;
    if (wr_ctrl) loc_ovr_d = wr_data[1];
    if (wr_stat) begin
      cfg_sel_d = wr_data[FIELD_W];
      idx_d     = wr_data[FIELD_W-1:0];
    end
    if (wr_offs) off_d = wr_data[RAW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_ovr_q <= 1'b0;
      cfg_sel_q <= 1'b0;
      idx_q     <= '0;
      off_q     <= RAW_W'(OFFSET_RESET);
    end else begin
      loc_ovr_q <= loc_ovr_d;
      cfg_sel_q <= cfg_sel_d;
      idx_q     <= idx_d;
      off_q     <= off_d;
    end
  end

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_cfg
    assign cfg_we[i] = wr_data_sel && cfg_sel_q && (idx_q == FIELD_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[i] <= '0;
      else if (cfg_we[i]) cfg_q[i] <= cfg_word_t'(wr_data);
    end
  end

  assign cfg_word  = (idx_q <= LAST_IDX) ? cfg_q[idx_q] : '0;
  assign start_req = wr_ctrl && wr_data[0];
  assign start_ovr = loc_ovr_d;
  assign loc_ovr   = loc_ovr_q;
  assign cfg_sel   = cfg_sel_q;
  assign idx       = idx_q;
  assign offset    = off_q;
endmodule

// File: rtl/acq_offset_sat.sv
`timescale 1ns/1ps
module acq_offset_sat #(
  parameter int RAW_W = 13
) (
  input  logic [RAW_W-1:0]        raw,
  input  logic signed [RAW_W-1:0] offset,
  output logic [RAW_W-1:0]        corrected
);
  localparam int SUM_W = RAW_W + 2;

  logic signed [SUM_W-1:0] raw_ext, off_ext, sum;

  assign raw_ext = $signed({2'b00, raw});
  assign off_ext = $signed({{2{offset[RAW_W-1]}}, offset});
  assign sum     = raw_ext + off_ext;

  always_comb begin
    if (sum[SUM_W-1])      corrected = '0;
    else if (sum[RAW_W])   corrected = '1;
    else                   corrected = sum[RAW_W-1:0];
  end
endmodule

// File: rtl/acq_result_buf.sv
`timescale 1ns/1ps
module acq_result_buf
  import adc_ctl_pkg::*;
#(
  parameter int RAW_W   = 13,
  parameter int NUM_LOC = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [FIELD_W-1:0] waddr,
  input  logic [RAW_W-1:0]   wdata,
  input  logic [FIELD_W-1:0] raddr,
  output logic [RAW_W-1:0]   rdata
);
  localparam logic [FIELD_W-1:0] LAST_LOC = FIELD_W'(NUM_LOC - 1);

  logic [RAW_W-1:0]   slot_q [NUM_LOC];
  logic [NUM_LOC-1:0] slot_we;

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_slot
    assign slot_we[i] = we && (waddr == FIELD_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[i] <= '0;
      else if (slot_we[i]) slot_q[i] <= wdata;
    end
  end

  assign rdata = (raddr <= LAST_LOC) ? slot_q[raddr] : '0;
endmodule

// File: rtl/acq_conv_fsm.sv
`timescale 1ns/1ps
module acq_conv_fsm
  import adc_ctl_pkg::*;
#(
  parameter int RAW_W   = 13,
  parameter int NUM_LOC = 25
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_req,
  input  logic                    start_ovr,
  input  logic [FIELD_W-1:0]      cfg_chan,
  input  logic [FIELD_W-1:0]      cfg_alt,
  input  logic                    cfg_diff,
  input  logic [1:0]              cfg_gain,
  input  logic signed [RAW_W-1:0] offset,
  input  logic [RAW_W-1:0]        sample,
  input  logic                    sample_valid,
  output logic                    busy,
  output logic                    done,
  output logic                    adc_start,
  output logic [FIELD_W-1:0]      adc_chan,
  output logic                    adc_diff,
  output logic [1:0]              adc_gain,
  output logic                    adc_gnd_sel,
  output logic                    buf_we,
  output logic [FIELD_W-1:0]      buf_addr,
  output logic [RAW_W-1:0]        buf_data
);
  localparam logic [FIELD_W-1:0] LAST_LOC = FIELD_W'(NUM_LOC - 1);
  localparam logic [FIELD_W-1:0] GND_CHAN = FIELD_W'(NUM_LOC);

  conv_state_e        state_q, state_d;
  logic [FIELD_W-1:0] chan_q, chan_d;
  logic               diff_q, diff_d;
  logic [1:0]         gain_q, gain_d;
  logic [FIELD_W-1:0] slot_q, slot_d;
  logic               slot_ok_q, slot_ok_d;
  logic [RAW_W-1:0]   res_q, res_d;
  logic               done_q, done_d;
  logic [RAW_W-1:0]   corrected;

  acq_offset_sat #(.RAW_W(RAW_W)) u_sat (
    .raw       (sample),
    .offset    (offset),
    .corrected (corrected)
  );

  always_comb begin
    state_d   = state_q;
    chan_d    = chan_q;
    diff_d    = diff_q;
    gain_d    = gain_q;
    slot_d    = slot_q;
    slot_ok_d = slot_ok_q;
    res_d     = res_q;
    done_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d   = ST_REQ;
          chan_d    = cfg_chan;
          diff_d    = cfg_diff;
          gain_d    = cfg_gain;
          slot_d    = start_ovr ? cfg_alt : cfg_chan;
          slot_ok_d = (slot_d <= LAST_LOC);
        end
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (sample_valid) begin
          res_d   = corrected;
          state_d = ST_STORE;
        end
      end
      ST_STORE: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      chan_q    <= '0;
      diff_q    <= 1'b0;
      gain_q    <= '0;
      slot_q    <= '0;
      slot_ok_q <= 1'b0;
      res_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      chan_q    <= chan_d;
      diff_q    <= diff_d;
      gain_q    <= gain_d;
      slot_q    <= slot_d;
      slot_ok_q <= slot_ok_d;
      res_q     <= res_d;
      done_q    <= done_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign adc_start   = (state_q == ST_REQ);
  assign adc_chan    = chan_q;
  assign adc_diff    = diff_q;
  assign adc_gain    = gain_q;
  assign adc_gnd_sel = (chan_q == GND_CHAN);
  assign buf_we      = (state_q == ST_STORE) && slot_ok_q;
  assign buf_addr    = slot_q;
  assign buf_data    = res_q;
endmodule

// File: rtl/adc_offset_conv_ctrl.sv
`timescale 1ns/1ps
module adc_offset_conv_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int RAW_W        = 13,
  parameter int NUM_LOC      = 25,
  parameter int OFFSET_RESET = -3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_wr_addr,
  input  logic [15:0]      reg_wr_data,
  input  logic [1:0]       reg_rd_addr,
  output logic [15:0]      reg_rd_data,
  output logic             conv_busy,
  output logic             conv_done,
  output logic             adc_start,
  output logic [4:0]       adc_chan,
  output logic             adc_diff,
  output logic [1:0]       adc_gain,
  output logic             adc_gnd_sel,
  input  logic [12:0]      adc_sample,
  input  logic             adc_sample_valid
);
  localparam int PAD_W  = REG_W - RAW_W;
  localparam int STAT_W = REG_W - FIELD_W - 1;

  logic [1:0]              rst_sync_q;
  logic                    rst_core_n;
  logic                    start_req, start_ovr, loc_ovr, cfg_sel;
  logic [FIELD_W-1:0]      idx;
  logic signed [RAW_W-1:0] offset;
  cfg_word_t               cfg_word;
  logic                    buf_we;
  logic [FIELD_W-1:0]      buf_addr;
  logic [RAW_W-1:0]        buf_wdata, buf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  acq_regs #(
    .RAW_W(RAW_W), .NUM_LOC(NUM_LOC), .OFFSET_RESET(OFFSET_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .start_req (start_req),
    .start_ovr (start_ovr),
    .loc_ovr   (loc_ovr),
    .cfg_sel   (cfg_sel),
    .idx       (idx),
    .offset    (offset),
    .cfg_word  (cfg_word)
  );

  acq_conv_fsm #(.RAW_W(RAW_W), .NUM_LOC(NUM_LOC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .start_req    (start_req),
    .start_ovr    (start_ovr),
    .cfg_chan     (cfg_word.chan),
    .cfg_alt      (cfg_word.alt_loc),
    .cfg_diff     (cfg_word.diff),
    .cfg_gain     (cfg_word.gain),
    .offset       (offset),
    .sample       (adc_sample),
    .sample_valid (adc_sample_valid),
    .busy         (conv_busy),
    .done         (conv_done),
    .adc_start    (adc_start),
    .adc_chan     (adc_chan),
    .adc_diff     (adc_diff),
    .adc_gain     (adc_gain),
    .adc_gnd_sel  (adc_gnd_sel),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .buf_data     (buf_wdata)
  );

  acq_result_buf #(.RAW_W(RAW_W), .NUM_LOC(NUM_LOC)) u_buf (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (buf_we),
    .waddr (buf_addr),
    .wdata (buf_wdata),
    .raddr (idx),
    .rdata (buf_rdata)
  );

  always_comb begin
    case (reg_rd_addr)
      REG_CTRL: reg_rd_data = {{(REG_W-2){1'b0}}, loc_ovr, conv_busy};
      REG_STAT: reg_rd_data = {{STAT_W{1'b0}}, cfg_sel, idx};
      REG_DATA: reg_rd_data = cfg_sel ? REG_W'(cfg_word)
                                      : {{PAD_W{1'b0}}, buf_rdata};
      default:  reg_rd_data = {{PAD_W{offset[RAW_W-1]}}, offset};
    endcase
  end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
`timescale 1ns/1ps
module adc_conv_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       adc_start,
  input logic [4:0] adc_chan,
  input logic       adc_gnd_sel
);
  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  // R4
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adc_start) |-> $stable(adc_chan));
  // R5
  gnd_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (adc_gnd_sel == (adc_chan == 5'd25)));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

bind adc_offset_conv_ctrl adc_conv_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (conv_busy),
  .done        (conv_done),
  .adc_start   (adc_start),
  .adc_chan    (adc_chan),
  .adc_gnd_sel (adc_gnd_sel)
);

// File: tb/adc_offset_conv_ctrl_bench.sv
`timescale 1ns/1ps
module adc_offset_conv_ctrl_bench;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_OFFS = 2'd3;
  localparam int NVEC = 10;
  // {chan, alt, ovr, offset, raw, exp_slot (31 = none), exp_value}
  localparam logic [54:0] VEC [NVEC] = '{
    {5'd3,  5'd0,  1'b0, 13'h0000, 13'd100,  5'd3,  13'd100},
    {5'd7,  5'd0,  1'b0, 13'h0005, 13'd8190, 5'd7,  13'd8191},
    {5'd24, 5'd0,  1'b0, 13'h1FF6, 13'd4,    5'd24, 13'd0},
    {5'd25, 5'd4,  1'b1, 13'h0000, 13'd37,   5'd4,  13'd37},
    {5'd10, 5'd0,  1'b1, 13'h1FDB, 13'd1000, 5'd0,  13'd963},
    {5'd0,  5'd9,  1'b0, 13'h0FFF, 13'd4096, 5'd0,  13'd8191},
    {5'd12, 5'd0,  1'b0, 13'h1000, 13'd4096, 5'd12, 13'd0},
    {5'd27, 5'd3,  1'b0, 13'h0001, 13'd50,   5'd31, 13'd0},
    {5'd2,  5'd26, 1'b1, 13'h0000, 13'd60,   5'd31, 13'd0},
    {5'd25, 5'd24, 1'b1, 13'h1FFE, 13'd1,    5'd24, 13'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_addr, reg_rd_addr;
  logic [15:0] reg_wr_data, reg_rd_data;
  logic        conv_busy, conv_done, adc_start, adc_diff, adc_gnd_sel;
  logic [4:0]  adc_chan;
  logic [1:0]  adc_gain;
  logic [12:0] adc_sample;
  logic        adc_sample_valid;

  int checks = 0;
  int errors = 0;
  int model [25];

  always #2 clk = ~clk;

  adc_offset_conv_ctrl u_adc_offset_conv_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .conv_busy(conv_busy), .conv_done(conv_done), .adc_start(adc_start),
    .adc_chan(adc_chan), .adc_diff(adc_diff), .adc_gain(adc_gain),
    .adc_gnd_sel(adc_gnd_sel), .adc_sample(adc_sample),
    .adc_sample_valid(adc_sample_valid)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] v);
    reg_rd_addr = a;
    #1;
    v = reg_rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 25; i++) model[i] = 0;
  endtask

  task automatic check_buffer(input string req);
    logic [15:0] v;
    for (int s = 0; s < 25; s++) begin
      reg_write(A_STAT, 16'(s));
      reg_read(A_DATA, v);
      chk($sformatf("%s buffer slot %0d", req, s), int'(v), model[s]);
    end
  endtask

  // called right after the start write has been captured
  task automatic run_conv(input logic [12:0] raw, input int exp_chan);
    chk("R4 adc_start pulse", int'(adc_start), 1);
    chk("R4 adc_chan", int'(adc_chan), exp_chan);
    chk("R5 adc_gnd_sel", int'(adc_gnd_sel), (exp_chan == 25) ? 1 : 0);
    @(negedge clk);
    adc_sample = raw; adc_sample_valid = 1'b1;
    @(negedge clk);
    adc_sample_valid = 1'b0;
    chk("R9 busy while storing", int'(conv_busy), 1);
    chk("R9 no early done", int'(conv_done), 0);
    @(negedge clk);
    chk("R9 done pulse", int'(conv_done), 1);
    chk("R9 busy low at done", int'(conv_busy), 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0; reg_rd_addr = '0;
    adc_sample = '0; adc_sample_valid = 1'b0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 busy", int'(conv_busy), 0);
    chk("R1 done", int'(conv_done), 0);
    reg_read(A_CTRL, v); chk("R1 ctrl", int'(v), 0);
    reg_read(A_STAT, v); chk("R1 stat", int'(v), 0);
    reg_read(A_OFFS, v); chk("R1 offset factory", int'(v), 16'hFFFD);
    reg_read(A_DATA, v); chk("R1 buffer slot0", int'(v), 0);
    reg_write(A_STAT, 16'h0020);
    reg_read(A_DATA, v); chk("R1 config entry0", int'(v), 0);

    // vector table: R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      logic [4:0]  ch, alt, slot;
      logic        ovr;
      logic [12:0] off, raw, ev;
      {ch, alt, ovr, off, raw, slot, ev} = VEC[k];
      reg_write(A_OFFS, {{3{off[12]}}, off});
      reg_read(A_OFFS, v);
      chk("R8 offset readback", int'(v), int'({{3{off[12]}}, off}));
      reg_write(A_STAT, 16'h0020);
      reg_write(A_DATA, {1'b0, 2'b00, alt, 2'b00, 1'b0, ch});
      reg_write(A_STAT, 16'h0000);
      reg_write(A_CTRL, {14'd0, ovr, 1'b1});
      run_conv(raw, int'(ch));
      if (slot != 5'd31) model[slot] = int'(ev);
      check_buffer($sformatf("R6 R7 R8 vec%0d", k));
    end

    // R2 configuration write/read, out-of-range index
    reg_write(A_STAT, 16'h0027);
    reg_write(A_DATA, 16'h6439);
    reg_read(A_DATA, v); chk("R2 config entry7", int'(v), 16'h6439);
    reg_write(A_STAT, 16'h003E);
    reg_write(A_DATA, 16'h1111);
    reg_read(A_DATA, v); chk("R2 config index 30 reads 0", int'(v), 0);

    // R4 field decode: entry7 = chan 25, diff, gain code 3, alt 4, override off
    reg_write(A_OFFS, 16'h0000);
    reg_write(A_STAT, 16'h0007);
    reg_write(A_CTRL, 16'h0001);
    chk("R4 adc_diff", int'(adc_diff), 1);
    chk("R4 adc_gain", int'(adc_gain), 3);
    run_conv(13'd77, 25);
    check_buffer("R6 ground channel without override");

    // R10 start while busy
    reg_write(A_STAT, 16'h0020);
    reg_write(A_DATA, 16'h0005);
    reg_write(A_STAT, 16'h0000);
    reg_write(A_CTRL, 16'h0001);
    chk("R10 first adc_start", int'(adc_start), 1);
    @(negedge clk);
    reg_write(A_CTRL, 16'h0001);
    chk("R10 no restart while busy", int'(adc_start), 0);
    adc_sample = 13'd200; adc_sample_valid = 1'b1;
    @(negedge clk);
    adc_sample_valid = 1'b0;
    @(negedge clk);
    chk("R10 single done", int'(conv_done), 1);
    @(negedge clk);
    chk("R10 no second adc_start", int'(adc_start), 0);
    chk("R10 idle after", int'(conv_busy), 0);
    chk("R10 no second done", int'(conv_done), 0);
    model[5] = 200;
    check_buffer("R10");

    // R3 data write with config-select off has no effect
    reg_write(A_STAT, 16'h0005);
    reg_write(A_DATA, 16'h0ABC);
    reg_read(A_DATA, v); chk("R3 buffer unchanged", int'(v), 200);
    reg_write(A_STAT, 16'h0020);
    reg_read(A_DATA, v); chk("R3 config entry0 unchanged", int'(v), 16'h0005);

    // R11 reset discards calibration
    reg_write(A_OFFS, 16'h0123);
    reg_read(A_OFFS, v); chk("R11 calibrated value", int'(v), 16'h0123);
    do_reset();
    reg_read(A_OFFS, v); chk("R11 factory value restored", int'(v), 16'hFFFD);
    check_buffer("R1 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule